// File: doc/BRIEF.md
# Prioritised Interrupt Level Controller

This block collects up to 31 interrupt sources and reduces them to one request level for the processor. Sources 1 to 15 map straight onto priority levels 1 to 15. Sources 16 to 31 form an extended bank, and any unmasked pending source in that bank raises one shared primary level, set by the `EXT_LEVEL` parameter. Each source is captured on its rising edge into a sticky pending bit. It can be masked individually and is cleared by software through a write-one-to-clear register.

The highest pending, unmasked level is compared against the processor's current interrupt level and its global trap-enable bit. When the request is allowed, the block asserts a trap request together with the matching trap type. Level 15 ignores the processor level but still obeys trap-enable. Software finds the extended source that fired by reading a source-identification register.

The register port uses a 2-bit address:
- offset 0: pending (read only)
- offset 1: mask (read/write)
- offset 2: clear (write one to clear, reads zero)
- offset 3: extended-source identification (read only)

Top module: `irq_lvl_ctrl`

## Requirements
- R1: A rising edge on source n (1 to 31, sampled on the clock) sets pending bit n one clock edge later. The bit stays set until it is cleared. Source bit 0 never sets a pending bit.
- R2: Writing to offset 2 clears every pending bit whose data bit is 1. If a new edge arrives on the same clock as the clear of that bit, the bit stays set. Reads at offset 2 return 0.
- R3: Mask bit n (offset 1, read/write, 1 = masked) stops source n from contributing to the presented level and the extended identification. Pending capture for that source still happens.
- R4: The presented level is the highest n in 1 to 15 whose pending bit is set and unmasked. Level `EXT_LEVEL` (default 10) also counts as active when any extended source 16 to 31 is pending and unmasked. With nothing active, the level is 0.
- R5: No trap request is raised while the trap-enable input is low, whatever the level.
- R6: A level from 1 to 14 raises a request only when it is strictly greater than the processor interrupt level. A processor level of 15 therefore blocks levels 1 to 14.
- R7: Level 15 raises a request whenever trap-enable is high, regardless of the processor interrupt level.
- R8: While a request is raised, the trap type output equals 0x10 plus the presented level. Otherwise the trap type output is 0.
- R9: A read at offset 3 returns 16 plus the index of the highest pending, unmasked extended source, or 0 if there is none.
- R10: A read at offset 0 returns the pending vector. Writes to offsets 0 and 3 change no state.
- R11: After reset, pending and mask are all zero, the request is low, and the level and trap type are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 32 | Interrupt source lines. Bit 0 is unused. |
| pil_i | input | 4 | Current processor interrupt level |
| et_i | input | 1 | Global trap enable |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register offset |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data for `addr_i` (combinational) |
| irq_req_o | output | 1 | Trap request to the processor |
| irq_level_o | output | 4 | Presented priority level |
| irq_tt_o | output | 8 | Trap type for the request |

## Verification
Directed patterns isolate one source at a time:
- a lone level against a processor level equal to it and just below it, which separates the `<=` rule from `<`;
- level 15 under a processor level of 15 and then with trap-enable low, which separates the level bypass from the trap-enable gate;
- an extended source alone, which checks both the folded level and the identification read;
- a clear issued on the same cycle as a new edge, which shows which of the two wins.

A long run of sparse random edges then follows, with random processor levels, mask writes, clears and stray writes. Several sources are pending at once in that run, so the priority order, the per-source masks and the fold of the extended bank are all checked against a model kept in the bench.

// File: rtl/irq_lvl_pkg.sv
package irq_lvl_pkg;
   typedef enum logic [1:0] {
      REG_PEND  = 2'd0,
      REG_MASK  = 2'd1,
      REG_CLR   = 2'd2,
      REG_EXTID = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/irq_pend_bank.sv
// Edge capture, sticky pending bits and the per-source mask register.
module irq_pend_bank #(
   parameter int SRC_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SRC_W-1:0] src_i,
   input  logic             wr_en_i,
   input  logic [1:0]       addr_i,
   input  logic [SRC_W-1:0] wdata_i,
   output logic [SRC_W-1:0] pend_o,
   output logic [SRC_W-1:0] mask_o
);
   import irq_lvl_pkg::*;

   localparam logic [SRC_W-1:0] LIVE = {{(SRC_W-1){1'b1}}, 1'b0};

   logic [SRC_W-1:0] src_q, pend_q, mask_q, rise, clr;

   assign rise = src_i & ~src_q & LIVE;
   assign clr  = (wr_en_i && addr_i == REG_CLR) ? wdata_i : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q  <= '0;
         pend_q <= '0;
         mask_q <= '0;
      end else begin
         src_q  <= src_i;
         pend_q <= (pend_q & ~clr) | rise;
         if (wr_en_i && addr_i == REG_MASK)
            mask_q <= wdata_i;
      end
   end

   assign pend_o = pend_q;
   assign mask_o = mask_q;
endmodule

// File: rtl/irq_prio_enc.sv
// Highest-set-bit encoder.
module irq_prio_enc #(
   parameter int W = 16,
   localparam int IW = $clog2(W)
) (
   input  logic [W-1:0]  in_i,
   output logic [IW-1:0] idx_o,
   output logic          valid_o
);
   if (W < 2) begin : g_bad_w
      $error("irq_prio_enc: W must be at least 2");
   end

   always_comb begin
      idx_o   = '0;
      valid_o = 1'b0;
      for (int i = 0; i < W; i++) begin
         if (in_i[i]) begin
            idx_o   = IW'(i);
            valid_o = 1'b1;
         end
      end
   end
endmodule

// File: rtl/irq_gate.sv
// Compares the level with the processor level and trap enable, and forms the trap type.
module irq_gate #(
   parameter int         LVL_W   = 4,
   parameter logic [7:0] TT_BASE = 8'h10
) (
   input  logic [LVL_W-1:0] level_i,
   input  logic [LVL_W-1:0] pil_i,
   input  logic             et_i,
   output logic             req_o,
   output logic [7:0]       tt_o
);
   localparam logic [LVL_W-1:0] NMI_LVL = '1;

   logic above;
   assign above = (level_i == NMI_LVL) || (level_i > pil_i);
   assign req_o = et_i && (level_i != '0) && above;
   assign tt_o  = req_o ? (TT_BASE + 8'(level_i)) : 8'h00;
endmodule

// File: rtl/irq_lvl_ctrl.sv
module irq_lvl_ctrl #(
   parameter int         NUM_LEVELS = 16,
   parameter int         NUM_EXT    = 16,
   parameter int         EXT_LEVEL  = 10,
   parameter logic [7:0] TT_BASE    = 8'h10,
   localparam int        SRC_W      = NUM_LEVELS + NUM_EXT,
   localparam int        LVL_W      = $clog2(NUM_LEVELS),
   localparam int        EXT_IW     = $clog2(NUM_EXT)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SRC_W-1:0] src_i,
   input  logic [LVL_W-1:0] pil_i,
   input  logic             et_i,
   input  logic             wr_en_i,
   input  logic [1:0]       addr_i,
   input  logic [SRC_W-1:0] wdata_i,
   output logic [SRC_W-1:0] rdata_o,
   output logic             irq_req_o,
   output logic [LVL_W-1:0] irq_level_o,
   output logic [7:0]       irq_tt_o
);
   import irq_lvl_pkg::*;

   if ((1 << LVL_W) != NUM_LEVELS) begin : g_bad_levels
      $error("irq_lvl_ctrl: NUM_LEVELS must be a power of two");
   end
   if (EXT_LEVEL < 1 || EXT_LEVEL > NUM_LEVELS - 2) begin : g_bad_ext
      $error("irq_lvl_ctrl: EXT_LEVEL must lie between 1 and NUM_LEVELS-2");
   end

   logic [SRC_W-1:0]      pend, mask, live;
   logic [NUM_EXT-1:0]    ext_vec;
   logic [EXT_IW-1:0]     ext_idx;
   logic                  ext_any;
   logic [NUM_LEVELS-1:0] lvl_vec;
   logic [LVL_W-1:0]      lvl_idx;
   logic                  lvl_any;
   logic [SRC_W-1:0]      ext_id;

   irq_pend_bank #(.SRC_W(SRC_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_en_i(wr_en_i),
      .addr_i(addr_i), .wdata_i(wdata_i), .pend_o(pend), .mask_o(mask)
   );

   assign live    = pend & ~mask;
   assign ext_vec = live[SRC_W-1:NUM_LEVELS];

   irq_prio_enc #(.W(NUM_EXT)) u_ext_enc (
      .in_i(ext_vec), .idx_o(ext_idx), .valid_o(ext_any)
   );

   assign lvl_vec[0] = 1'b0;
   for (genvar n = 1; n < NUM_LEVELS; n++) begin : g_lvl
      if (n == EXT_LEVEL) begin : g_fold
         assign lvl_vec[n] = live[n] | ext_any;
      end else begin : g_plain
         assign lvl_vec[n] = live[n];
      end
   end

   irq_prio_enc #(.W(NUM_LEVELS)) u_lvl_enc (
      .in_i(lvl_vec), .idx_o(lvl_idx), .valid_o(lvl_any)
   );

   assign irq_level_o = lvl_any ? lvl_idx : '0;

   irq_gate #(.LVL_W(LVL_W), .TT_BASE(TT_BASE)) u_gate (
      .level_i(irq_level_o), .pil_i(pil_i), .et_i(et_i),
      .req_o(irq_req_o), .tt_o(irq_tt_o)
   );

   assign ext_id = ext_any ? SRC_W'(NUM_LEVELS + int'(ext_idx)) : '0;

   always_comb begin
      case (reg_sel_e'(addr_i))
         REG_PEND:  rdata_o = pend;
         REG_MASK:  rdata_o = mask;
         REG_EXTID: rdata_o = ext_id;
         default:   rdata_o = '0;
      endcase
   end
endmodule

// File: rtl/irq_lvl_ctrl_chk.sv
module irq_lvl_ctrl_chk #(
   parameter int SRC_W = 32,
   parameter int LVL_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             et_i,
   input logic [LVL_W-1:0] pil_i,
   input logic             wr_en_i,
   input logic [1:0]       addr_i,
   input logic [SRC_W-1:0] wdata_i,
   input logic [SRC_W-1:0] rdata_o,
   input logic             irq_req_o,
   input logic [LVL_W-1:0] irq_level_o,
   input logic [7:0]       irq_tt_o,
   input logic [SRC_W-1:0] pend
);
   logic [SRC_W-1:0] clr_vec;
   assign clr_vec = (wr_en_i && addr_i == 2'd2) ? wdata_i : '0;

   p_no_req_without_et_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !et_i |-> !irq_req_o);

   p_req_above_pil_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req_o && irq_level_o != '1) |-> (irq_level_o > pil_i));

   p_nmi_passes_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (et_i && irq_level_o == '1) |-> irq_req_o);

   p_level_zero_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_level_o == '0) |-> (!irq_req_o && irq_tt_o == 8'h00));

   p_tt_tracks_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req_o |-> (irq_tt_o[7:LVL_W] == 4'h1 && irq_tt_o[LVL_W-1:0] == irq_level_o));

   p_pend_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((($past(pend) & ~$past(clr_vec)) & ~pend) == '0));

   p_bit0_never_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !pend[0]);

   p_extid_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_i == 2'd3) |-> (rdata_o == '0 || (rdata_o >= 16 && rdata_o < SRC_W)));
endmodule

bind irq_lvl_ctrl irq_lvl_ctrl_chk #(.SRC_W(SRC_W), .LVL_W(LVL_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .et_i(et_i), .pil_i(pil_i), .wr_en_i(wr_en_i),
   .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_req_o(irq_req_o),
   .irq_level_o(irq_level_o), .irq_tt_o(irq_tt_o), .pend(pend)
);

// File: tb/irq_lvl_ctrl_tb.sv
module irq_lvl_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int EXT_LVL    = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] src_i = '0;
   logic [3:0]  pil_i = '0;
   logic        et_i = 1'b0;
   logic        wr_en_i = 1'b0;
   logic [1:0]  addr_i = '0;
   logic [31:0] wdata_i = '0;
   logic [31:0] rdata_o;
   logic        irq_req_o;
   logic [3:0]  irq_level_o;
   logic [7:0]  irq_tt_o;

   int n_chk = 0;
   int n_bad = 0;

   logic [31:0] m_pend = '0, m_mask = '0, m_prev = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_lvl_ctrl #(.EXT_LEVEL(EXT_LVL)) dut_i (
      .clk(clk), .rst_n(rst_n), .src_i(src_i), .pil_i(pil_i), .et_i(et_i),
      .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
      .irq_req_o(irq_req_o), .irq_level_o(irq_level_o), .irq_tt_o(irq_tt_o)
   );

   function automatic logic [3:0] f_level(logic [31:0] p, logic [31:0] m);
      logic [31:0] lv = p & ~m;
      logic [3:0] r = 4'd0;
      for (int n = 1; n < 16; n++)
         if (lv[n] || (n == EXT_LVL && lv[31:16] != 16'h0)) r = 4'(n);
      return r;
   endfunction

   function automatic logic f_req(logic [3:0] lv, logic [3:0] pil, logic et);
      return et && lv != 0 && (lv == 4'd15 || lv > pil);
   endfunction

   function automatic logic [31:0] f_extid(logic [31:0] p, logic [31:0] m);
      logic [31:0] lv = p & ~m;
      logic [31:0] r = 32'd0;
      for (int n = 16; n < 32; n++) if (lv[n]) r = 32'(n);
      return r;
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   // One cycle: drive at negedge, check outputs, then update the model at posedge.
   task automatic step(logic [31:0] s, logic [3:0] p, logic e,
                       logic w, logic [1:0] a, logic [31:0] d);
      logic [3:0]  lv;
      logic        rq;
      logic [31:0] rexp;
      logic [31:0] rise, clr;
      @(negedge clk);
      src_i = s; pil_i = p; et_i = e; wr_en_i = w; addr_i = a; wdata_i = d;
      #1;
      lv = f_level(m_pend, m_mask);
      rq = f_req(lv, p, e);
      check("R4 level", 32'(irq_level_o), 32'(lv));
      if (!e)            check("R5 req", 32'(irq_req_o), 32'(rq));
      else if (lv == 15) check("R7 req", 32'(irq_req_o), 32'(rq));
      else               check("R6 req", 32'(irq_req_o), 32'(rq));
      check("R8 tt", 32'(irq_tt_o), rq ? 32'(8'h10 + 8'(lv)) : 32'd0);
      case (a)
         2'd0: begin rexp = m_pend; check("R1/R10 pending read", rdata_o, rexp); end
         2'd1: begin rexp = m_mask; check("R3 mask read", rdata_o, rexp); end
         2'd2: check("R2 clear reads zero", rdata_o, 32'd0);
         default: begin rexp = f_extid(m_pend, m_mask); check("R9 ext id", rdata_o, rexp); end
      endcase
      @(posedge clk);
      rise   = s & ~m_prev & 32'hFFFF_FFFE;
      clr    = (w && a == 2'd2) ? d : 32'd0;
      m_pend = (m_pend & ~clr) | rise;
      if (w && a == 2'd1) m_mask = d;
      m_prev = s;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      logic [31:0] s;
      void'($urandom(32'd5150));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R11 reset req", 32'(irq_req_o), 32'd0);
      check("R11 reset level", 32'(irq_level_o), 32'd0);
      check("R11 reset tt", 32'(irq_tt_o), 32'd0);
      addr_i = 2'd0; #1; check("R11 reset pending", rdata_o, 32'd0);
      addr_i = 2'd1; #1; check("R11 reset mask", rdata_o, 32'd0);

      // R1/R4/R6: lone level 5 against processor levels 5 and 4
      step(32'h20, 4'd0, 1'b1, 1'b0, 2'd0, 0);
      step(32'h20, 4'd5, 1'b1, 1'b0, 2'd0, 0);
      step(32'h20, 4'd4, 1'b1, 1'b0, 2'd0, 0);
      // source 0 edge ignored (R1)
      step(32'h21, 4'd4, 1'b1, 1'b0, 2'd0, 0);
      step(32'h21, 4'd4, 1'b1, 1'b0, 2'd0, 0);
      // R7: level 15 with pil 15, then R5 with et low
      step(32'h8021, 4'd15, 1'b1, 1'b0, 2'd0, 0);
      step(32'h8021, 4'd15, 1'b1, 1'b0, 2'd0, 0);
      step(32'h8021, 4'd15, 1'b0, 1'b0, 2'd0, 0);
      // R3: mask 15, level falls back to 5
      step(32'h8021, 4'd0, 1'b1, 1'b1, 2'd1, 32'h8000);
      step(32'h8021, 4'd0, 1'b1, 1'b0, 2'd1, 0);
      // R9: extended source 20 folds onto EXT_LVL
      step(32'h0010_8021, 4'd0, 1'b1, 1'b0, 2'd3, 0);
      step(32'h0010_8021, 4'd0, 1'b1, 1'b0, 2'd3, 0);
      // R10: writes to pending and ext id offsets ignored
      step(32'h0010_8021, 4'd0, 1'b1, 1'b1, 2'd0, 32'hFFFF_FFFF);
      step(32'h0010_8021, 4'd0, 1'b1, 1'b1, 2'd3, 32'h0);
      step(32'h0010_8021, 4'd0, 1'b1, 1'b0, 2'd0, 0);
      // R2: clear everything, then clear of bit 7 with a fresh edge on 7
      step(32'h0010_8021, 4'd0, 1'b1, 1'b1, 2'd2, 32'hFFFF_FFFF);
      step(32'h0000_0000, 4'd0, 1'b1, 1'b0, 2'd0, 0);
      step(32'h0000_0080, 4'd0, 1'b1, 1'b1, 2'd2, 32'h80);
      step(32'h0000_0080, 4'd0, 1'b1, 1'b0, 2'd0, 0);
      step(32'h0000_0080, 4'd0, 1'b1, 1'b1, 2'd2, 32'hFFFF_FFFF);
      step(32'h0000_0080, 4'd0, 1'b1, 1'b1, 2'd1, 32'h0);

      // Constrained random phase
      s = 32'h0;
      for (int i = 0; i < 3000; i++) begin
         logic [1:0]  a;
         logic        w;
         logic [31:0] d;
         s ^= $urandom & $urandom & $urandom;
         a = 2'($urandom);
         w = ($urandom % 4) == 0;
         d = (a == 2'd1) ? ($urandom & $urandom) : $urandom;
         step(s, 4'($urandom), ($urandom % 8) != 0, w, a, d);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule